// File: doc/BRIEF.md
# Two-Level Lookahead Adder/Subtractor

This block adds or subtracts two 16-bit operands with no clock and no state. Each operand bit pair forms a generate term (AND) and a propagate term (XOR). Every 4-bit slice reduces its four pairs to one slice generate and one slice propagate. A second lookahead stage, with the same form of equation, turns those slice terms into the carry that enters each slice. Inside a slice, every bit carry is expanded in full from the slice's incoming carry, so no carry ripples from bit to bit.

In subtract mode the second operand is inverted and the incoming carry is forced to 1, which gives A plus the two's complement of B. The outputs are the sum, the carry-out of the top bit, an unsigned overflow flag and a signed overflow flag. The width must be a multiple of 4.

Top module: `cla_addsub`

## Requirements
- R1: With `sub_mode`=0, `{carry_out, sum}` equals `op_a + op_b + carry_in`, taken as a 17-bit unsigned value.
- R2: With `sub_mode`=1, `sum` equals `(op_a - op_b) mod 2^16` and `carry_in` has no effect. `carry_out` is 1 exactly when `op_a >= op_b` as unsigned values.
- R3: `ovf_unsigned` always equals the carry out of bit 15, which is the same value as `carry_out`.
- R4: `ovf_signed` is 1 exactly when the carry into bit 15 differs from the carry out of bit 15. This is the case where `op_a` and the effective second operand (`op_b`, or `~op_b` when subtracting) share bit 15 and `sum[15]` differs from it.
- R5: 0x7FFF + 0x0001 with `carry_in`=0 gives a sum of 0x8000, `carry_out`=0 and `ovf_signed`=1.
- R6: 0xFFFF + 0x0001 with `carry_in`=0 gives a sum of 0x0000, `carry_out`=1, `ovf_unsigned`=1 and `ovf_signed`=0.
- R7: 0x8000 − 0x0001 gives a sum of 0x7FFF, `carry_out`=1 and `ovf_signed`=1.
- R8: When every slice propagates (0xFFFF + 0x0000 with `carry_in`=1), the incoming carry crosses all four slices in one step. The sum is 0x0000 and `carry_out` is 1.
- R9: The outputs depend only on the current inputs. A new input vector gives its result in the same clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand (the subtrahend when subtracting) |
| sub_mode | input | 1 | 1 selects A − B, 0 selects A + B |
| carry_in | input | 1 | Incoming carry for addition; ignored when subtracting |
| sum | output | 16 | Result |
| carry_out | output | 1 | Carry out of bit 15 |
| ovf_unsigned | output | 1 | Unsigned overflow flag |
| ovf_signed | output | 1 | Two's complement overflow flag |

## Verification
The hardest case to reach is a carry that the second lookahead level must carry across several slices that all propagate. Random operands almost never make a run of 4-bit slices all propagate. The stimulus therefore adds directed vectors of the form 0xFFFF, 0x0FFF and 0x00FF plus a small value or an incoming carry, and subtraction vectors whose operands are equal or differ by one. These drive a carry from slice 0 into slices 1, 2, 3 and out through the top. The three overflow boundaries are applied directly, and random vectors are mixed in around them.

// File: rtl/cla_addsub.sv
module cla_addsub #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             sub_mode,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out,
  output logic             ovf_unsigned,
  output logic             ovf_signed
);
  localparam int NG  = WIDTH / 4;
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff, gen, prop;
  logic             c0;
  logic [NG-1:0]    grp_g, grp_p;
  logic [NG:0]      grp_c;
  logic [WIDTH:0]   bit_c;

  assign b_eff = sub_mode ? ~op_b : op_b;
  assign c0    = sub_mode | carry_in;
  assign gen   = op_a & b_eff;
  assign prop  = op_a ^ b_eff;

  // first level: slice generate / propagate
  always_comb begin
    for (int j = 0; j < NG; j++) begin
      grp_p[j] = &prop[4*j +: 4];
      grp_g[j] = gen[4*j+3]
               | (gen[4*j+2] & prop[4*j+3])
               | (gen[4*j+1] & prop[4*j+2] & prop[4*j+3])
               | (gen[4*j]   & prop[4*j+1] & prop[4*j+2] & prop[4*j+3]);
    end
  end

  // second level: carry into each slice, expanded from c0
  always_comb begin
    logic acc, run;
    for (int j = 0; j <= NG; j++) begin
      acc = 1'b0;
      run = 1'b1;
      for (int k = j - 1; k >= 0; k--) begin
        acc = acc | (grp_g[k] & run);
        run = run & grp_p[k];
      end
      grp_c[j] = acc | (run & c0);
    end
  end

  // bit carries inside each slice, expanded from the slice carry
  always_comb begin
    logic acc, run;
    for (int j = 0; j < NG; j++) begin
      for (int i = 0; i < 4; i++) begin
        acc = 1'b0;
        run = 1'b1;
        for (int k = i - 1; k >= 0; k--) begin
          acc = acc | (gen[4*j+k] & run);
          run = run & prop[4*j+k];
        end
        bit_c[4*j+i] = acc | (run & grp_c[j]);
      end
    end
    bit_c[WIDTH] = grp_c[NG];
  end

  assign sum          = prop ^ bit_c[WIDTH-1:0];
  assign carry_out    = bit_c[WIDTH];
  assign ovf_unsigned = bit_c[WIDTH];
  assign ovf_signed   = bit_c[WIDTH] ^ bit_c[MSB];

  // checks
  always_comb begin
    if (!$isunknown({op_a, op_b, sub_mode, carry_in})) begin
      p_add_result_r1: assert ({carry_out, sum} ==
        ({1'b0, op_a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, c0}))
        else $error("R1 result mismatch");
      if (sub_mode) begin
        p_sub_result_r2: assert (sum == WIDTH'(op_a - op_b) && carry_out == (op_a >= op_b))
          else $error("R2 subtract mismatch");
      end
      p_uovf_r3: assert (ovf_unsigned == carry_out)
        else $error("R3 unsigned flag mismatch");
      p_sovf_r4: assert (ovf_signed ==
        ((op_a[MSB] == b_eff[MSB]) && (sum[MSB] != op_a[MSB])))
        else $error("R4 signed flag mismatch");
      for (int j = 1; j <= NG; j++) begin
        p_slice_carry_r8: assert (grp_c[j] ==
          (((WIDTH+1)'(op_a & ((WIDTH'(1) << (4*j)) - 1)) +
            (WIDTH+1)'(b_eff & ((WIDTH'(1) << (4*j)) - 1)) +
            (WIDTH+1)'(c0)) >> (4*j)) != 0)
          else $error("R8 slice carry mismatch");
      end
    end
  end
endmodule

// File: tb/test_cla_addsub.sv
module test_cla_addsub;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [W-1:0] op_a = '0, op_b = '0, sum;
  logic sub_mode = 1'b0, carry_in = 1'b0;
  logic carry_out, ovf_unsigned, ovf_signed;

  cla_addsub #(.WIDTH(W)) i_cla_addsub (
    .op_a(op_a), .op_b(op_b), .sub_mode(sub_mode), .carry_in(carry_in),
    .sum(sum), .carry_out(carry_out), .ovf_unsigned(ovf_unsigned),
    .ovf_signed(ovf_signed)
  );

  typedef struct {
    logic [W-1:0] s;
    logic co, uo, so;
    string tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(logic [W-1:0] a, logic [W-1:0] b, logic sm, logic ci, string tag);
    exp_t e;
    logic [W-1:0] be;
    logic [W:0]   full;
    @(posedge clk);
    op_a = a; op_b = b; sub_mode = sm; carry_in = ci;
    if (sm) begin
      full = {1'b0, a} - {1'b0, b};
      e.s  = full[W-1:0];
      e.co = (a >= b);
      be   = ~b;
    end else begin
      full = {1'b0, a} + {1'b0, b} + (W+1)'(ci);
      e.s  = full[W-1:0];
      e.co = full[W];
      be   = b;
    end
    e.uo  = e.co;
    e.so  = (a[W-1] == be[W-1]) && (e.s[W-1] != a[W-1]);
    e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: result is combinational, so compare half a period later
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(e.tag, "sum", sum, e.s);
      chk(e.tag, "carry_out", W'(carry_out), W'(e.co));
      chk(e.tag, "ovf_unsigned", W'(ovf_unsigned), W'(e.uo));
      chk(e.tag, "ovf_signed", W'(ovf_signed), W'(e.so));
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    // R1 reset state: all-zero inputs give all-zero outputs
    @(negedge clk);
    chk("R1", "reset sum", sum, '0);
    chk("R1", "reset flags", W'({carry_out, ovf_unsigned, ovf_signed}), '0);
    rst_n = 1'b1;

    // R5, R6, R7 overflow boundaries
    drive(16'h7FFF, 16'h0001, 1'b0, 1'b0, "R5");
    drive(16'hFFFF, 16'h0001, 1'b0, 1'b0, "R6");
    drive(16'h8000, 16'h0001, 1'b1, 1'b0, "R7");
    drive(16'h8000, 16'h0001, 1'b1, 1'b1, "R7");
    // R8 carries crossing the slices
    drive(16'hFFFF, 16'h0000, 1'b0, 1'b1, "R8");
    drive(16'h0FFF, 16'h0000, 1'b0, 1'b1, "R8");
    drive(16'h00FF, 16'h0001, 1'b0, 1'b0, "R8");
    drive(16'h000F, 16'h0001, 1'b0, 1'b0, "R8");
    // R2 subtraction corners; carry_in must have no effect
    drive(16'h1234, 16'h1234, 1'b1, 1'b0, "R2");
    drive(16'h1234, 16'h1234, 1'b1, 1'b1, "R2");
    drive(16'h0000, 16'h0001, 1'b1, 1'b0, "R2");
    drive(16'h0000, 16'h0001, 1'b1, 1'b1, "R2");
    drive(16'h7FFF, 16'h8000, 1'b1, 1'b0, "R4");
    drive(16'h8000, 16'h8000, 1'b0, 1'b0, "R4");
    // R9 back-to-back vectors, one per clock period
    drive(16'hAAAA, 16'h5555, 1'b0, 1'b1, "R9");
    drive(16'h5555, 16'hAAAA, 1'b0, 1'b0, "R9");
    // R1/R2/R3/R4 random operands
    for (int n = 0; n < 300; n++) begin
      drive(W'($urandom), W'($urandom), 1'(n % 3 == 0), 1'($urandom), n % 3 == 0 ? "R2" : "R1");
    end
    for (int n = 0; n < 100; n++) begin
      drive(W'($urandom) | 16'h7F00, W'($urandom) | 16'h7F00, 1'($urandom), 1'($urandom), "R3");
    end
    repeat (3) @(posedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule